// File: doc/BRIEF.md
# Sinc1 Sigma-Delta Demodulator Channel

This block is one channel of a sigma-delta demodulator. A 1-bit modulator stream and the modulator's own clock enter asynchronously. Both pass through two-flop synchronizers. Each rising modulator clock edge then adds +1 (bit high) or -1 (bit low) to an accumulator. After a programmable number of bits, the sum is dumped into a 32-bit two's-complement data word and the accumulator restarts from zero. This makes a first-order sinc (accumulate-and-dump) decimator. There is no settling period, so the first word after enabling is already a true sum.

Every dumped word is compared, as a signed number, against a high limit and a low limit. A watchdog counts system clocks between modulator clock edges and reports a lost modulator clock. All events land in sticky status bits that software clears by writing ones to a clear register. A master bit collects the events whose interrupt enable is set and drives the interrupt pin. The modulator clock must run at no more than a quarter of the system clock.

Register map (3-bit word address, 16-bit data):
- 0: control. Bit 0 is enable. Bits 1 to 4 are the interrupt enables for ready, high, low and clock-fail.
- 1: decimation ratio.
- 2: high limit, signed.
- 3: low limit, signed.
- 4: data bits 31:16.
- 5: data bits 15:0.
- 6: status. Bit 0 is ready, bit 1 is high, bit 2 is low, bit 3 is clock-fail and bit 4 is master.
- 7: clear. Writes only; reads return 0.

Top module: `sd_sinc1_chan`

## Requirements
- R1: After reset the status register, both data halves and `intOut` read 0. The ratio reads 16 and the channel is disabled.
- R2: With ratio N, each word equals the count of 1 bits minus the count of 0 bits over N consecutive modulator bits, so it lies in -N..+N. This holds for N = 16 and N = 4.
- R3: The very first word after enable is a correct sum, with no discarded start-up words.
- R4: The word is sign-extended to 32 bits. Address 4 returns bits 31:16 and address 5 returns bits 15:0 (for example, -16 reads as 0xFFFF and 0xFFF0).
- R5: Status bit 0 (ready) sets each time a new word is stored.
- R6: Status bit 1 sets when a word is strictly greater than the signed high limit. A word equal to the limit does not set it.
- R7: Status bit 2 sets when a word is strictly less than the signed low limit. A word equal to the limit does not set it.
- R8: While enabled, status bit 3 sets once 64 system clocks pass without a rising modulator clock edge. It is still clear 40 cycles after the last edge.
- R9: Writing to address 7 clears exactly the status bits written as 1. If a bit's set event arrives in the same cycle as its clear, the set wins.
- R10: Master bit 4 sets when a status bit sets while its interrupt enable is 1. It stays set after the source bit is cleared, until bit 4 itself is cleared. An event whose enable is 0 leaves it clear. `intOut` follows bit 4.
- R11: While disabled, modulator edges produce no words and no status bits, and the stored data word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modClk | input | 1 | Modulator clock, asynchronous |
| modData | input | 1 | Modulator bitstream, valid at rising modClk |
| regAddr | input | 3 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Register read data, combinational from regAddr |
| intOut | output | 1 | Master interrupt |

## Verification
The watchdog's timeout event and a software clear of the same status bit can fall in the same system clock. The bench provokes this in two identical stall trials. The first trial stops the modulator clock at a fixed alignment and measures in which cycle the clock-fail bit appears. The second trial repeats the stall and places a clear write of that bit exactly on the measured edge. The bit must then read 1, and only a later clear may remove it. The decimator's dump and the threshold comparison also share one edge. They are judged together by a scoreboard that pairs every read word with its expected high and low bits, including words sitting exactly on each limit.

// File: rtl/sd_sinc1_pkg.sv
package sd_sinc1_pkg;
  localparam int unsigned BUS_W  = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FLAG_N = 5;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_RATIO = 3'd1;
  localparam logic [2:0] A_HI    = 3'd2;
  localparam logic [2:0] A_LO    = 3'd3;
  localparam logic [2:0] A_DHI   = 3'd4;
  localparam logic [2:0] A_DLO   = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;
  localparam logic [2:0] A_CLR   = 3'd7;

  localparam int F_RDY  = 0;
  localparam int F_HI   = 1;
  localparam int F_LO   = 2;
  localparam int F_FAIL = 3;
  localparam int F_MST  = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic bitStb;
    logic bitVal;
    logic dumpStb;
    logic clrAcc;
  } dpCtl_t;
endpackage

// File: rtl/sd_sinc1_sync.sv
module sd_sinc1_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shiftQ;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftQ <= '0;
        else       shiftQ <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) shiftQ <= '0;
        else       shiftQ <= {shiftQ[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shiftQ[STAGES-1];
endmodule

// File: rtl/sd_sinc1_dp.sv
module sd_sinc1_dp
  import sd_sinc1_pkg::*;
#(
  parameter int unsigned RATIO_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [BUS_W-1:0]  hiThr,
  input  logic [BUS_W-1:0]  loThr,
  output logic [DATA_W-1:0] dataQ,
  output logic              evtRdy,
  output logic              evtHi,
  output logic              evtLo
);
  localparam int unsigned ACC_W = RATIO_W + 2;

  logic signed [ACC_W-1:0]  acc;
  logic signed [ACC_W-1:0]  accSum;
  logic signed [DATA_W-1:0] sumWide;
  logic signed [DATA_W-1:0] hiWide;
  logic signed [DATA_W-1:0] loWide;

  always_comb begin
    accSum  = ctl.bitVal ? acc + ACC_W'(1) : acc - ACC_W'(1);
    sumWide = {{(DATA_W-ACC_W){accSum[ACC_W-1]}}, accSum};
    hiWide  = {{(DATA_W-BUS_W){hiThr[BUS_W-1]}}, hiThr};
    loWide  = {{(DATA_W-BUS_W){loThr[BUS_W-1]}}, loThr};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else if (ctl.clrAcc || ctl.dumpStb) begin
      acc <= '0;
    end else if (ctl.bitStb) begin
      acc <= accSum;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      evtRdy <= 1'b0;
      evtHi  <= 1'b0;
      evtLo  <= 1'b0;
    end else begin
      evtRdy <= ctl.dumpStb;
      evtHi  <= ctl.dumpStb && (sumWide > hiWide);
      evtLo  <= ctl.dumpStb && (sumWide < loWide);
      if (ctl.dumpStb) dataQ <= sumWide;
    end
  end
endmodule

// File: rtl/sd_sinc1_ctrl.sv
module sd_sinc1_ctrl
  import sd_sinc1_pkg::*;
#(
  parameter int unsigned RATIO_W = 8,
  parameter int unsigned TIMEOUT = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               clkS,
  input  logic               datS,
  input  logic [2:0]         regAddr,
  input  logic               regWrEn,
  input  logic [BUS_W-1:0]   regWdata,
  output logic [BUS_W-1:0]   regRdata,
  input  logic [DATA_W-1:0]  dataQ,
  input  logic               evtRdy,
  input  logic               evtHi,
  input  logic               evtLo,
  output dpCtl_t             ctl,
  output logic [BUS_W-1:0]   hiThr,
  output logic [BUS_W-1:0]   loThr,
  output logic [FLAG_N-1:0]  status,
  output logic               enQ,
  output logic [RATIO_W-1:0] ratioQ,
  output logic               intOut
);
  localparam int unsigned WD_W = $clog2(TIMEOUT + 1);
  localparam int unsigned IE_N = FLAG_N - 1;

  logic              clkPrev;
  logic              rise;
  logic [RATIO_W-1:0] bitCnt;
  logic [RATIO_W:0]   cntNext;
  logic [WD_W-1:0]    wdCnt;
  logic               failEvt;
  logic [IE_N-1:0]    ieQ;
  logic [IE_N-1:0]    setVec;
  logic [FLAG_N-1:0]  clrVec;
  logic               mstSet;

  // edge detection on the synchronized modulator clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) clkPrev <= 1'b0;
    else       clkPrev <= clkS;
  end
  assign rise = clkS && !clkPrev;

  // decimation counting and strobes
  always_comb begin
    cntNext     = {1'b0, bitCnt} + {{RATIO_W{1'b0}}, 1'b1};
    ctl         = '0;
    ctl.clrAcc  = !enQ;
    ctl.bitStb  = enQ && rise;
    ctl.bitVal  = datS;
    ctl.dumpStb = enQ && rise && (cntNext >= {1'b0, ratioQ});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (!enQ || ctl.dumpStb) begin
      bitCnt <= '0;
    end else if (ctl.bitStb) begin
      bitCnt <= cntNext[RATIO_W-1:0];
    end
  end

  // modulator clock watchdog
  assign failEvt = enQ && !rise && (wdCnt == WD_W'(TIMEOUT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wdCnt <= '0;
    end else if (!enQ || rise) begin
      wdCnt <= '0;
    end else if (wdCnt != WD_W'(TIMEOUT)) begin
      wdCnt <= wdCnt + WD_W'(1);
    end
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= 1'b0;
      ieQ    <= '0;
      ratioQ <= RATIO_W'(16);
      hiThr  <= {1'b0, {(BUS_W-1){1'b1}}};
      loThr  <= {1'b1, {(BUS_W-1){1'b0}}};
    end else if (regWrEn) begin
      case (regAddr)
        A_CTRL: begin
          enQ <= regWdata[0];
          ieQ <= regWdata[IE_N:1];
        end
        A_RATIO: ratioQ <= regWdata[RATIO_W-1:0];
        A_HI:    hiThr  <= regWdata;
        A_LO:    loThr  <= regWdata;
        default: ;
      endcase
    end
  end

  // sticky status, write-one-to-clear, set has priority
  always_comb begin
    setVec         = '0;
    setVec[F_RDY]  = evtRdy;
    setVec[F_HI]   = evtHi;
    setVec[F_LO]   = evtLo;
    setVec[F_FAIL] = failEvt;
    mstSet         = |(setVec & ieQ);
    clrVec         = (regWrEn && regAddr == A_CLR) ? regWdata[FLAG_N-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) status <= '0;
    else       status <= (status & ~clrVec) | {mstSet, setVec};
  end

  assign intOut = status[F_MST];

  // read mux
  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CTRL:  regRdata = BUS_W'({ieQ, enQ});
      A_RATIO: regRdata = BUS_W'(ratioQ);
      A_HI:    regRdata = hiThr;
      A_LO:    regRdata = loThr;
      A_DHI:   regRdata = dataQ[DATA_W-1:BUS_W];
      A_DLO:   regRdata = dataQ[BUS_W-1:0];
      A_STAT:  regRdata = BUS_W'(status);
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/sd_sinc1_chan.sv
module sd_sinc1_chan
  import sd_sinc1_pkg::*;
#(
  parameter int unsigned RATIO_W     = 8,
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modClk,
  input  logic        modData,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  output logic        intOut
);
  localparam int unsigned N_SYNC = 2;

  logic [N_SYNC-1:0]  rawIn;
  logic [N_SYNC-1:0]  syncOut;
  dpCtl_t             ctl;
  logic [BUS_W-1:0]   hiThr;
  logic [BUS_W-1:0]   loThr;
  logic [DATA_W-1:0]  dataQ;
  logic               evtRdy;
  logic               evtHi;
  logic               evtLo;
  logic [FLAG_N-1:0]  status;
  logic               enQ;
  logic [RATIO_W-1:0] ratioQ;

  assign rawIn = {modData, modClk};

  for (genvar i = 0; i < N_SYNC; i++) begin : g_sync
    sd_sinc1_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rstN (rstN),
      .din  (rawIn[i]),
      .dout (syncOut[i])
    );
  end

  sd_sinc1_ctrl #(.RATIO_W(RATIO_W), .TIMEOUT(TIMEOUT)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clkS     (syncOut[0]),
    .datS     (syncOut[1]),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .dataQ    (dataQ),
    .evtRdy   (evtRdy),
    .evtHi    (evtHi),
    .evtLo    (evtLo),
    .ctl      (ctl),
    .hiThr    (hiThr),
    .loThr    (loThr),
    .status   (status),
    .enQ      (enQ),
    .ratioQ   (ratioQ),
    .intOut   (intOut)
  );

  sd_sinc1_dp #(.RATIO_W(RATIO_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .hiThr  (hiThr),
    .loThr  (loThr),
    .dataQ  (dataQ),
    .evtRdy (evtRdy),
    .evtHi  (evtHi),
    .evtLo  (evtLo)
  );
endmodule

// File: rtl/sd_sinc1_chk.sv
module sd_sinc1_chk #(
  parameter int unsigned RATIO_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [2:0]         regAddr,
  input logic [15:0]        regWdata,
  input logic [4:0]         status,
  input logic               evtRdy,
  input logic [31:0]        dataQ,
  input logic [RATIO_W-1:0] ratioQ,
  input logic               enQ
);
  logic signed [31:0] dSig;
  logic signed [31:0] rSig;
  logic               clrWr;

  assign dSig  = dataQ;
  assign rSig  = {{(32-RATIO_W){1'b0}}, ratioQ};
  assign clrWr = regWrEn && (regAddr == 3'd7);

  AST_DATA_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (evtRdy && ratioQ != '0) |-> (dSig <= rSig && dSig >= -rSig)); // R2

  AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    evtRdy |=> status[0]); // R5

  AST_CLR_RDY: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && regWdata[0] && !evtRdy) |=> !status[0]); // R9

  AST_MASTER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (status[4] && !(clrWr && regWdata[4])) |=> status[4]); // R10

  AST_FAIL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(status[3]) |-> $past(enQ)); // R11
endmodule

bind sd_sinc1_chan sd_sinc1_chk #(.RATIO_W(RATIO_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .regWdata (regWdata),
  .status   (status),
  .evtRdy   (evtRdy),
  .dataQ    (dataQ),
  .ratioQ   (ratioQ),
  .enQ      (enQ)
);

// File: tb/sd_sinc1_chan_test.sv
module sd_sinc1_chan_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modClk = 1'b0;
  logic        modData = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWdata = 16'd0;
  logic [15:0] regRdata;
  logic        intOut;

  int nTests = 0;
  int nFail  = 0;
  int hiT = 0;
  int loT = 0;

  typedef struct {
    int val;
    bit hi;
    bit lo;
  } exp_t;
  exp_t q[$];

  sd_sinc1_chan uut (
    .clk(clk), .rstN(rstN), .modClk(modClk), .modData(modData),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWdata(regWdata),
    .regRdata(regRdata), .intOut(intOut)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic busRead(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr  = a;
    regWdata = d;
    regWrEn  = 1'b1;
    @(negedge clk);
    regWrEn  = 1'b0;
  endtask

  task automatic driveBit(input logic b);
    modData = b;
    #(CLK_P*4) modClk = 1'b1;
    #(CLK_P*4) modClk = 1'b0;
  endtask

  // driver: pushes the expected word, then plays its bits
  task automatic driveWord(input int n, input logic [255:0] pat);
    exp_t e;
    int s = 0;
    for (int i = 0; i < n; i++) s += pat[i] ? 1 : -1;
    e.val = s;
    e.hi  = (s > hiT);
    e.lo  = (s < loT);
    q.push_back(e);
    for (int i = 0; i < n; i++) driveBit(pat[i]);
  endtask

  // monitor: polls ready, reads the word, compares against the queue
  task automatic monitorWords(input int n);
    int got = 0;
    logic [15:0] f, h, l;
    exp_t e;
    while (got < n) begin
      busRead(3'd6, f);
      if (f[0]) begin
        busRead(3'd4, h);
        busRead(3'd5, l);
        if (q.size() == 0) begin
          check("R5 unexpected word", {h, l}, 32'hxxxx_xxxx);
        end else begin
          e = q.pop_front();
          check("R2 R3 R4 word value", {h, l}, e.val);
          check("R6 high flag", 32'(f[1]), 32'(e.hi));
          check("R7 low flag", 32'(f[2]), 32'(e.lo));
        end
        busWrite(3'd7, 16'h001F);
        got++;
      end
    end
  endtask

  function automatic logic [255:0] onesLow(input int k);
    return (256'(1) << k) - 256'(1);
  endfunction

  function automatic logic [255:0] rnd256();
    return {$urandom, $urandom, $urandom, $urandom,
            $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin : watchdog
    #(CLK_P * 150000);
    nFail++;
    nTests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin : main
    logic [15:0] r, h0, l0;
    int c;
    int meas;

    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    busRead(3'd6, r); check("R1 status after reset", 32'(r), 0);
    busRead(3'd4, r); check("R1 data high after reset", 32'(r), 0);
    busRead(3'd5, r); check("R1 data low after reset", 32'(r), 0);
    busRead(3'd1, r); check("R1 ratio after reset", 32'(r), 16);
    busRead(3'd0, r); check("R1 control after reset", 32'(r), 0);
    check("R1 intOut after reset", 32'(intOut), 0);

    // ratio 16, limits +10 / -10, enable; first word is checked too (R3)
    hiT = 10; loT = -10;
    busWrite(3'd2, 16'(hiT));
    busWrite(3'd3, 16'(loT));
    busWrite(3'd0, 16'h0001);
    fork
      begin
        driveWord(16, '1);
        driveWord(16, '0);
        driveWord(16, {128{2'b10}});
        driveWord(16, onesLow(13));
        driveWord(16, onesLow(3));
        driveWord(16, onesLow(14));
        driveWord(16, onesLow(2));
        for (int i = 0; i < 4; i++) driveWord(16, rnd256());
      end
      monitorWords(11);
    join

    // explicit R4 halves for -16
    busWrite(3'd7, 16'h001F);
    driveWord(16, '0);
    void'(q.pop_back());
    repeat (8) @(negedge clk);
    busRead(3'd4, r); check("R4 high half of -16", 32'(r), 32'h0000FFFF);
    busRead(3'd5, r); check("R4 low half of -16", 32'(r), 32'h0000FFF0);

    // ratio 4 stream
    busWrite(3'd0, 16'h0000);
    busWrite(3'd1, 16'd4);
    hiT = 3; loT = -3;
    busWrite(3'd2, 16'(hiT));
    busWrite(3'd3, 16'(loT));
    busWrite(3'd7, 16'h001F);
    busWrite(3'd0, 16'h0001);
    fork
      begin
        driveWord(4, '1);
        driveWord(4, '0);
        driveWord(4, {128{2'b10}});
        driveWord(4, onesLow(3));
        driveWord(4, onesLow(1));
        for (int i = 0; i < 3; i++) driveWord(4, rnd256());
      end
      monitorWords(8);
    join

    // R10 master with ready enabled
    busWrite(3'd2, 16'd2);
    busWrite(3'd7, 16'h001F);
    busWrite(3'd0, 16'h0003);
    driveWord(4, '1);
    void'(q.pop_back());
    repeat (8) @(negedge clk);
    busRead(3'd6, r); check("R10 ready plus master", 32'(r), 32'h13);
    check("R10 intOut high", 32'(intOut), 1);
    busWrite(3'd7, 16'h0001);
    busRead(3'd6, r); check("R9 R10 only ready cleared, master kept", 32'(r), 32'h12);
    check("R10 intOut held", 32'(intOut), 1);
    busWrite(3'd7, 16'h0010);
    busRead(3'd6, r); check("R9 master cleared", 32'(r), 32'h02);
    check("R10 intOut low after clear", 32'(intOut), 0);

    // R10 events with enable off do not set master
    busWrite(3'd7, 16'h001F);
    busWrite(3'd0, 16'h0011);
    driveWord(4, '1);
    void'(q.pop_back());
    repeat (8) @(negedge clk);
    busRead(3'd6, r); check("R10 no master from disabled sources", 32'(r), 32'h03);
    check("R10 intOut stays low", 32'(intOut), 0);

    // R8 watchdog, trial 1: measure
    busWrite(3'd0, 16'h0001);
    busWrite(3'd7, 16'h001F);
    @(negedge clk);
    for (int i = 0; i < 4; i++) driveBit(1'b1);
    meas = 0;
    regAddr = 3'd6;
    for (c = 1; c <= 200; c++) begin
      @(negedge clk);
      #1;
      if (c == 40) check("R8 no clock-fail at 40 cycles", 32'(regRdata[3]), 0);
      if (regRdata[3] && meas == 0) meas = c;
    end
    check("R8 clock-fail seen within 41..80 cycles", 32'(meas >= 41 && meas <= 80), 1);

    // R9 trial 2: clear lands on the set edge, set wins
    busWrite(3'd7, 16'h001F);
    @(negedge clk);
    for (int i = 0; i < 4; i++) driveBit(1'b1);
    repeat (meas - 1) @(negedge clk);
    regAddr  = 3'd7;
    regWdata = 16'h0008;
    regWrEn  = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    regAddr = 3'd6;
    #1 check("R9 set wins over same-cycle clear", 32'(regRdata[3]), 1);
    busWrite(3'd7, 16'h0008);
    busRead(3'd6, r); check("R9 later clear removes clock-fail", 32'(r[3]), 0);

    // R11 disabled: no words, no flags, data kept
    busRead(3'd4, h0);
    busRead(3'd5, l0);
    busWrite(3'd0, 16'h001E);
    busWrite(3'd7, 16'h001F);
    for (int i = 0; i < 12; i++) driveBit(1'b0);
    repeat (100) @(negedge clk);
    busRead(3'd6, r); check("R11 no status while disabled", 32'(r), 0);
    check("R11 intOut low while disabled", 32'(intOut), 0);
    busRead(3'd4, r); check("R11 data high kept", 32'(r), 32'(h0));
    busRead(3'd5, r); check("R11 data low kept", 32'(r), 32'(l0));

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule